// File: doc/BRIEF.md
# Deferred Save Trimmer

This block sits on the save-instruction path of an instruction-driven convolution engine that can be preempted between tasks of different priority. One ordinary save instruction often writes the final results of several consecutive output-channel groups at once. When a lower-priority task is preempted after one of those groups has finished, an extra "virtual" save runs first and writes out only that group's results.

The block records each executed virtual save per priority level. It keeps the ID of the ordinary save that the virtual save stands in for, and the length it has already written. When that ordinary save later arrives on the same level, the block moves its start address forward and shortens its length, so results already in memory are not transferred again. Every save instruction leaves the block through a single output register stage, with valid/ready handshakes on both sides.

Level 0 is the top priority and is never preempted, so it has no record. Levels 1 to NUM_LVL-1 each own one record.

Top module: `save_rewriter`

## Requirements
- R1: After reset `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: An ordinary save (`in_virt_i`=0) on a level with no valid record leaves with the same ID, address and length.
- R3: A virtual save (`in_virt_i`=1) leaves unchanged. On levels 1 and above it stores its ID and length as that level's valid record.
- R4: An ordinary save whose ID equals the valid record of its own level leaves with address = address + recorded length and length = length - recorded length.
- R5: If the recorded length is greater than or equal to the ordinary save's length, the save leaves with length 0 and address = address + recorded length.
- R6: A record is cleared when its matching ordinary save is accepted, so a later ordinary save with the same ID passes unchanged.
- R7: An ordinary save whose ID differs from its level's valid record passes unchanged, and the record is kept.
- R8: Records are private to each level. A record on one level never changes a save on another level.
- R9: Saves on level 0, whether virtual or ordinary, pass unchanged and are never recorded.
- R10: A virtual save whose ID matches its level's valid record adds its length to the recorded length. A virtual save with a different ID replaces the record.
- R11: Each accepted input appears on the output one cycle later. `in_ready_o` is high when the output register is empty or is being drained. While `out_valid_o` is high and `out_ready_i` is low, the output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input save instruction valid |
| in_ready_o | output | 1 | Input accepted when high together with valid |
| in_virt_i | input | 1 | 1 = virtual save, 0 = ordinary save |
| in_lvl_i | input | LVL_W | Priority level of the issuing task (0 = highest) |
| in_id_i | input | ID_W | Save ID linking a virtual save to its ordinary save |
| in_addr_i | input | ADDR_W | Destination start address |
| in_len_i | input | LEN_W | Transfer length |
| out_valid_o | output | 1 | Output save instruction valid |
| out_ready_i | input | 1 | Downstream ready |
| out_virt_o | output | 1 | Virtual flag passed through |
| out_id_o | output | ID_W | Save ID passed through |
| out_addr_o | output | ADDR_W | Possibly advanced start address |
| out_len_o | output | LEN_W | Possibly trimmed length |

## Verification
The bench builds the block with three levels and a 4-bit save ID. Random traffic therefore drawn from only a few IDs and two preemptible levels produces matches, mismatches, accumulating virtual saves and cross-level ID collisions often. Lengths are kept below 64 with a 12-bit length field, so trimming to zero and partial trimming both occur without arithmetic wrap. Random back-pressure on `out_ready_i` exercises stalls while a record is updated or cleared.

// File: rtl/save_rw_pkg.sv
package save_rw_pkg;
  typedef enum logic [1:0] {
    TRIM_NONE  = 2'd0,
    TRIM_PART  = 2'd1,
    TRIM_EMPTY = 2'd2
  } trim_kind_e;
endpackage

// File: rtl/save_record.sv
module save_record #(
  parameter int ID_W  = 4,
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [LEN_W-1:0] wr_len_i,
  input  logic             clr_i,
  output logic             vld_o,
  output logic [ID_W-1:0]  id_o,
  output logic [LEN_W-1:0] len_o
);
  logic             vld_q;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] len_q;
  logic             same_id;

  assign same_id = vld_q && (id_q == wr_id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      id_q  <= '0;
      len_q <= '0;
    end else if (wr_i) begin
      vld_q <= 1'b1;
      id_q  <= wr_id_i;
      // further preemption inside the same save group extends coverage
      len_q <= same_id ? len_q + wr_len_i : wr_len_i;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end
  end

  assign vld_o = vld_q;
  assign id_o  = id_q;
  assign len_o = len_q;

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_i) |=> !vld_q);  // R6
  AST_WR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (vld_q && id_q == $past(wr_id_i)));  // R3
endmodule

// File: rtl/save_trim.sv
module save_trim
  import save_rw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              hit_i,
  input  logic [LEN_W-1:0]  rec_len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output trim_kind_e        kind_o
);
  logic covers_all;

  assign covers_all = (rec_len_i >= len_i);

  always_comb begin
    addr_o = addr_i;
    len_o  = len_i;
    kind_o = TRIM_NONE;
    if (hit_i) begin
      addr_o = addr_i + ADDR_W'(rec_len_i);
      if (covers_all) begin
        len_o  = '0;
        kind_o = TRIM_EMPTY;
      end else begin
        len_o  = len_i - rec_len_i;
        kind_o = TRIM_PART;
      end
    end
  end

  always_comb begin
    AST_LEN_SHRINKS: assert (len_o <= len_i);  // R4
  end
endmodule

// File: rtl/save_rewriter.sv
module save_rewriter
  import save_rw_pkg::*;
#(
  parameter int NUM_LVL = 3,
  parameter int ID_W    = 4,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 12,
  localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_virt_i,
  input  logic [LVL_W-1:0]  in_lvl_i,
  input  logic [ID_W-1:0]   in_id_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [LEN_W-1:0]  in_len_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_virt_o,
  output logic [ID_W-1:0]   out_id_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [LEN_W-1:0]  out_len_o
);
  logic                 fire;
  logic                 lvl_ok;
  logic [NUM_LVL-1:0]   rec_vld;
  logic [ID_W-1:0]      rec_id  [NUM_LVL];
  logic [LEN_W-1:0]     rec_len [NUM_LVL];
  logic                 sel_vld;
  logic [ID_W-1:0]      sel_id;
  logic [LEN_W-1:0]     sel_len;
  logic                 hit;
  logic [ADDR_W-1:0]    trim_addr;
  logic [LEN_W-1:0]     trim_len;
  trim_kind_e           trim_kind;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign fire       = in_valid_i && in_ready_o;
  assign lvl_ok     = (32'(in_lvl_i) < NUM_LVL) && (in_lvl_i != '0);

  // level 0 cannot be preempted and owns no record
  assign rec_vld[0] = 1'b0;
  assign rec_id[0]  = '0;
  assign rec_len[0] = '0;

  for (genvar g = 1; g < NUM_LVL; g++) begin : g_rec
    logic here;
    assign here = fire && lvl_ok && (32'(in_lvl_i) == g);
    save_record #(.ID_W(ID_W), .LEN_W(LEN_W)) i_rec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (here && in_virt_i),
      .wr_id_i  (in_id_i),
      .wr_len_i (in_len_i),
      .clr_i    (here && !in_virt_i && hit),
      .vld_o    (rec_vld[g]),
      .id_o     (rec_id[g]),
      .len_o    (rec_len[g])
    );
  end

  always_comb begin
    sel_vld = 1'b0;
    sel_id  = '0;
    sel_len = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      if (32'(in_lvl_i) == i) begin
        sel_vld = rec_vld[i];
        sel_id  = rec_id[i];
        sel_len = rec_len[i];
      end
    end
  end

  assign hit = !in_virt_i && lvl_ok && sel_vld && (sel_id == in_id_i);

  save_trim #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_trim (
    .hit_i     (hit),
    .rec_len_i (sel_len),
    .addr_i    (in_addr_i),
    .len_i     (in_len_i),
    .addr_o    (trim_addr),
    .len_o     (trim_len),
    .kind_o    (trim_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_virt_o  <= 1'b0;
      out_id_o    <= '0;
      out_addr_o  <= '0;
      out_len_o   <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_virt_o <= in_virt_i;
        out_id_o   <= in_id_i;
        out_addr_o <= trim_addr;
        out_len_o  <= trim_len;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> out_valid_o);  // R11
  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_addr_o)
      && $stable(out_len_o) && $stable(out_id_o) && $stable(out_virt_o)));  // R11
  AST_EMPTY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);  // R11
  AST_VIRT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_virt_i) |=> (out_addr_o == $past(in_addr_i) && out_len_o == $past(in_len_i)));  // R3
  AST_LVL0_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_lvl_i == '0) |=> (out_addr_o == $past(in_addr_i) && out_len_o == $past(in_len_i)));  // R9
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && trim_kind == TRIM_EMPTY) |=> (out_len_o == '0));  // R5
endmodule

// File: tb/test_save_rewriter.sv
module test_save_rewriter;
  localparam int NL = 3, IW = 4, AW = 32, LW = 12, LVW = 2, MAXN = 700;
  localparam int OW = 1 + IW + AW + LW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic in_valid_i = 0, in_virt_i = 0, out_ready_i = 1;
  logic [LVW-1:0] in_lvl_i = '0;
  logic [IW-1:0] in_id_i = '0;
  logic [AW-1:0] in_addr_i = '0;
  logic [LW-1:0] in_len_i = '0;
  logic in_ready_o, out_valid_o, out_virt_o;
  logic [IW-1:0] out_id_o;
  logic [AW-1:0] out_addr_o;
  logic [LW-1:0] out_len_o;

  save_rewriter #(.NUM_LVL(NL), .ID_W(IW), .ADDR_W(AW), .LEN_W(LW)) i_save_rewriter (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_virt_i, .in_lvl_i, .in_id_i,
    .in_addr_i, .in_len_i, .out_valid_o, .out_ready_i, .out_virt_o, .out_id_o,
    .out_addr_o, .out_len_o);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  bit             s_virt [MAXN];
  logic [LVW-1:0] s_lvl  [MAXN];
  logic [IW-1:0]  s_id   [MAXN];
  logic [AW-1:0]  s_addr [MAXN];
  logic [LW-1:0]  s_len  [MAXN];
  int n = 0, ptr = 0;

  bit            mv  [NL];
  logic [IW-1:0] mid [NL];
  logic [LW-1:0] mlen[NL];
  bit            cv  [NL];
  logic [IW-1:0] cid [NL];

  logic [OW-1:0] eq[$];
  string         et[$];

  bit acc = 0, prev_stall = 0, stall_en = 0;
  logic [OW-1:0] prev_out;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add(bit v, int l, int id, int a, int len);
    s_virt[n] = v; s_lvl[n] = LVW'(l); s_id[n] = IW'(id);
    s_addr[n] = AW'(a); s_len[n] = LW'(len); n++;
  endtask

  function automatic logic [OW-1:0] pack(bit v, logic [IW-1:0] id, logic [AW-1:0] a, logic [LW-1:0] l);
    return {v, id, a, l};
  endfunction

  task automatic model(int i);
    int l;
    logic [AW-1:0] ea;
    logic [LW-1:0] el;
    string tag;
    l = int'(s_lvl[i]);
    ea = s_addr[i];
    el = s_len[i];
    if (l == 0 || l >= NL) begin
      tag = "R9";
    end else if (s_virt[i]) begin
      if (mv[l] && mid[l] == s_id[i]) begin mlen[l] = mlen[l] + s_len[i]; tag = "R10"; end
      else begin tag = mv[l] ? "R10" : "R3"; mid[l] = s_id[i]; mlen[l] = s_len[i]; end
      mv[l] = 1; cv[l] = 0;
    end else if (mv[l] && mid[l] == s_id[i]) begin
      ea = s_addr[i] + AW'(mlen[l]);
      if (mlen[l] >= s_len[i]) begin el = '0; tag = "R5"; end
      else begin el = s_len[i] - mlen[l]; tag = "R4"; end
      mv[l] = 0; cv[l] = 1; cid[l] = s_id[i];
    end else if (mv[l]) begin
      tag = "R7";
    end else if (cv[l] && cid[l] == s_id[i]) begin
      tag = "R6";
    end else begin
      tag = "R2";
      for (int k = 1; k < NL; k++) if (k != l && mv[k] && mid[k] == s_id[i]) tag = "R8";
    end
    eq.push_back(pack(s_virt[i], s_id[i], ea, el));
    et.push_back(tag);
  endtask

  task automatic step();
    logic [OW-1:0] cur, e;
    string t;
    @(negedge clk_i);
    cyc++;
    if (acc) begin
      chk(out_valid_o == 1'b1, "R11", 64'(out_valid_o), 1);
      ptr++; acc = 0;
    end
    cur = pack(out_virt_o, out_id_o, out_addr_o, out_len_o);
    if (prev_stall) chk(out_valid_o && cur == prev_out, "R11", 64'(cur), 64'(prev_out));
    if (ptr < n) begin
      in_valid_i = 1; in_virt_i = s_virt[ptr]; in_lvl_i = s_lvl[ptr];
      in_id_i = s_id[ptr]; in_addr_i = s_addr[ptr]; in_len_i = s_len[ptr];
    end else in_valid_i = 0;
    out_ready_i = stall_en ? (($urandom % 3) != 0) : 1'b1;
    #1;
    chk(in_ready_o == (!out_valid_o || out_ready_i), "R11", 64'(in_ready_o), 64'(!out_valid_o || out_ready_i));
    if (out_valid_o && out_ready_i) begin
      if (eq.size() == 0) chk(0, "R11 unexpected output", 64'(cur), 0);
      else begin
        e = eq.pop_front(); t = et.pop_front();
        chk(cur == e, t, 64'(cur), 64'(e));
      end
    end
    prev_stall = out_valid_o && !out_ready_i;
    prev_out = cur;
    if (in_valid_i && in_ready_o) begin model(ptr); acc = 1; end
  endtask

  task automatic run();
    while ((ptr < n || acc || eq.size() != 0) && cyc < 150000) step();
  endtask

  initial begin
    for (int k = 0; k < NL; k++) begin mv[k] = 0; cv[k] = 0; mid[k] = '0; mlen[k] = '0; cid[k] = '0; end
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 0 && in_ready_o == 1, "R1", {out_valid_o, in_ready_o}, 2'b01);
    rst_ni = 1;
    // directed corners
    add(0, 1, 2, 'h1000, 40);            // R2 no record
    add(1, 1, 3, 'h2000, 16);            // R3 record
    add(0, 1, 3, 'h2000, 48);            // R4 trimmed
    add(0, 1, 3, 'h2000, 48);            // R6 record gone
    add(1, 2, 5, 'h3000, 20);            // R3 level 2
    add(0, 2, 6, 'h3100, 30);            // R7 mismatch keeps record
    add(0, 1, 5, 'h3000, 30);            // R8 other level
    add(0, 2, 5, 'h3000, 50);            // R4 trimmed
    add(1, 1, 7, 'h4000, 10);
    add(1, 1, 7, 'h400a, 12);            // R10 accumulate
    add(0, 1, 7, 'h4000, 22);            // R5 fully covered
    add(1, 0, 1, 'h5000, 8);             // R9 level 0 virtual
    add(0, 0, 1, 'h5000, 24);            // R9 level 0 ordinary
    add(1, 2, 4, 'h6000, 8);
    add(1, 2, 9, 'h6100, 6);             // R10 replace
    add(0, 2, 4, 'h6000, 20);            // R7
    add(0, 2, 9, 'h6100, 18);            // R4
    run();
    stall_en = 1;
    for (int r = 0; r < 600; r++) begin
      if (n >= MAXN) break;
      add(($urandom % 5) < 2, $urandom % NL, $urandom % 4, $urandom, 1 + ($urandom % 63));
    end
    run();
    if (cyc >= 150000) chk(0, "R11 drain timeout", 64'(eq.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule